// File: doc/BRIEF.md
# Receive Byte Queue with Character Timeout

This block is the receive half of a classic byte-oriented serial port controller. A bit-level front end hands it complete bytes (or a line-break event), and the block keeps them in a first-in first-out store until the processor reads them through a data-register read strobe. The block also maintains the receive status flags: data ready, overrun and break. A read strobe on the line status register clears overrun and break.

Two interrupt conditions are produced. The data-available condition fires when the store holds at least a programmable number of bytes. The character-timeout indication fires when bytes have sat unread for four frame times. A frame time is counted in baud ticks, one tick per bit, and the frame length comes from the current line settings. When queueing is switched off, the block holds a single byte, and a newer byte replaces an unread one.

Top module: `uart_rx_queue`

## Requirements
- R1: In queue mode, a byte or break that arrives while the store holds DEPTH entries is dropped, the stored entries stay unchanged, and `overrun` goes high.
- R2: In queue mode, `data_avail` is high when `data_ready` is set and `fill` is at least the trigger level picked by `trig_sel`: 2'b00 gives 1, 2'b01 gives 4, 2'b10 gives 8 and 2'b11 gives 14.
- R3: In queue mode, bytes come out on `rd_data` in arrival order. A data read of an empty store returns 8'h00.
- R4: After a restart, `timeout_ind` rises on the edge that takes in the Nth following baud tick, provided data is still stored. N = 4 × frame, and frame = 7 + `line_ctl`[1:0] + `line_ctl`[2] + `line_ctl`[3]. That frame counts a start bit, 5 to 8 data bits, an optional parity bit and 1 or 2 stop bits.
- R5: The timeout restarts on every incoming byte in queue mode, and on every data read that leaves the store non-empty. If the count runs out while the store is empty, no indication is raised.
- R6: A data read always clears `timeout_ind`.
- R7: `data_ready` and `brk` are cleared by a data read that leaves the store empty. In single-byte mode they are cleared by any data read.
- R8: A break event stores the byte 8'h00 and sets both `brk` and `data_ready`.
- R9: In single-byte mode, a byte that arrives while `data_ready` is set raises `overrun`, and the new byte replaces the held one on `rd_data`. In this mode `data_avail` follows `data_ready`.
- R10: A `fifo_clr` pulse, or any change of `fifo_en`, empties the store, clears `data_ready`, `brk` and `timeout_ind`, and cancels a running timeout.
- R11: Only `lsr_rd_stb` clears `overrun`. `brk` is also cleared by `lsr_rd_stb`. Data reads leave `overrun` unchanged.
- R12: A change of `line_ctl` while the timeout runs restarts it with the length for the new setting.
- R13: `timeout_ind` never rises in single-byte mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1 = queue mode, 0 = single-byte mode |
| fifo_clr | input | 1 | Pulse: empty the receive store |
| trig_sel | input | 2 | Trigger level code |
| line_ctl | input | 4 | [1:0] data length − 5, [2] second stop bit, [3] parity present |
| baud_tick | input | 1 | One pulse per bit time |
| rx_valid | input | 1 | A received byte is on `rx_data` |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | A line break was received |
| rd_stb | input | 1 | Data register read |
| lsr_rd_stb | input | 1 | Line status register read |
| rd_data | output | 8 | Byte returned by a data read |
| fill | output | 5 | Number of stored entries |
| data_ready | output | 1 | Data-ready flag |
| overrun | output | 1 | Overrun flag |
| brk | output | 1 | Break flag |
| data_avail | output | 1 | Trigger level reached |
| timeout_ind | output | 1 | Character timeout pending |

## Verification
The bench uses the default build: DEPTH of 16 and a timeout of four frames. With a depth of 16, every trigger code can be filled past its threshold and the store can be driven into overflow with one extra byte. All sixteen `line_ctl` settings are swept, so every timeout window from 28 to 48 ticks is checked one tick early and exactly on time. Separate passes cover break, clearing, rescaling and single-byte mode.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   // bit time count of one frame: start + data + parity + stop
   function automatic logic [3:0] frame_bits(input logic [3:0] lc);
      return 4'd7 + 4'(lc[1:0]) + 4'(lc[2]) + 4'(lc[3]);
   endfunction

   function automatic int trig_level(input logic [1:0] code);
      case (code)
         2'b00:   return 1;
         2'b01:   return 4;
         2'b10:   return 8;
         default: return 14;
      endcase
   endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int DEPTH = 16,
   parameter int W     = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr,
   input  logic                       push,
   input  logic                       pop,
   input  logic [W-1:0]               wdata,
   output logic [W-1:0]               rdata,
   output logic [$clog2(DEPTH+1)-1:0] level
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int LVL_W = $clog2(DEPTH+1);
   localparam bit POW2  = (DEPTH & (DEPTH - 1)) == 0;

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;

   generate
      if (POW2) begin : g_wrap_free
         assign wr_nxt = wr_ptr + PTR_W'(1);
         assign rd_nxt = rd_ptr + PTR_W'(1);
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         case ({push, pop})
            2'b10:   level <= level + LVL_W'(1);
            2'b01:   level <= level - LVL_W'(1);
            default: level <= level;
         endcase
      end
   end

   assign rdata = mem[rd_ptr];
endmodule

// File: rtl/rxq_frame_timer.sv
module rxq_frame_timer
   import rxq_pkg::*;
#(
   parameter int FRAMES = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] line_ctl,
   input  logic       restart,
   input  logic       cancel,
   input  logic       tick,
   output logic       expire
);
   localparam int CNT_W = $clog2(FRAMES * 12 + 1);

   logic [CNT_W-1:0] cnt;
   logic             run;
   logic [3:0]       lc_q;
   logic             lc_chg, reload;
   logic [CNT_W-1:0] load;

   assign load   = CNT_W'(FRAMES * int'(frame_bits(line_ctl)));
   assign lc_chg = line_ctl != lc_q;
   assign reload = restart || (run && lc_chg);
   assign expire = run && tick && (cnt == CNT_W'(1)) && !cancel && !reload;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         run  <= 1'b0;
         lc_q <= '0;
      end else begin
         lc_q <= line_ctl;
         if (cancel) begin
            run <= 1'b0;
         end else if (reload) begin
            cnt <= load;
            run <= 1'b1;
         end else if (run && tick) begin
            if (cnt == CNT_W'(1)) run <= 1'b0;
            else                  cnt <= cnt - CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
   import rxq_pkg::*;
#(
   parameter int DEPTH      = 16,
   parameter int TMO_FRAMES = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       fifo_en,
   input  logic                       fifo_clr,
   input  logic [1:0]                 trig_sel,
   input  logic [3:0]                 line_ctl,
   input  logic                       baud_tick,
   input  logic                       rx_valid,
   input  logic [7:0]                 rx_data,
   input  logic                       rx_break,
   input  logic                       rd_stb,
   input  logic                       lsr_rd_stb,
   output logic [7:0]                 rd_data,
   output logic [$clog2(DEPTH+1)-1:0] fill,
   output logic                       data_ready,
   output logic                       overrun,
   output logic                       brk,
   output logic                       data_avail,
   output logic                       timeout_ind
);
   localparam int LVL_W = $clog2(DEPTH+1);

   generate
      if (DEPTH < 14) begin : g_bad_depth
         $error("DEPTH must hold the largest trigger level");
      end
      if (TMO_FRAMES < 1) begin : g_bad_frames
         $error("TMO_FRAMES must be at least 1");
      end
   endgenerate

   logic       en_q, clr, in_pkt, full, push_ok, ovf, pop, leaves_empty;
   logic       restart, cancel, expire;
   logic [7:0] in_byte, hold, q_rdata;

   assign clr          = fifo_clr || (fifo_en != en_q);
   assign in_pkt       = rx_valid || rx_break;
   assign in_byte      = rx_break ? 8'h00 : rx_data;
   assign full         = fill == LVL_W'(DEPTH);
   assign push_ok      = fifo_en && in_pkt && !full && !clr;
   assign ovf          = !clr && in_pkt && (fifo_en ? full : data_ready);
   assign pop          = fifo_en && rd_stb && (fill != '0) && !clr;
   assign leaves_empty = rd_stb && (!fifo_en || fill <= LVL_W'(1));
   assign restart      = fifo_en && !clr && (in_pkt || (rd_stb && fill > LVL_W'(1)));
   assign cancel       = clr || !fifo_en;

   rxq_store #(.DEPTH(DEPTH), .W(8)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .push  (push_ok),
      .pop   (pop),
      .wdata (in_byte),
      .rdata (q_rdata),
      .level (fill)
   );

   rxq_frame_timer #(.FRAMES(TMO_FRAMES)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_ctl (line_ctl),
      .restart  (restart),
      .cancel   (cancel),
      .tick     (baud_tick),
      .expire   (expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q        <= 1'b0;
         hold        <= '0;
         data_ready  <= 1'b0;
         overrun     <= 1'b0;
         brk         <= 1'b0;
         timeout_ind <= 1'b0;
      end else begin
         en_q <= fifo_en;
         if (!fifo_en && in_pkt && !clr) hold <= in_byte;

         if (clr)               data_ready <= 1'b0;
         else if (in_pkt)       data_ready <= 1'b1;
         else if (leaves_empty) data_ready <= 1'b0;

         if (clr)                       brk <= 1'b0;
         else if (rx_break)             brk <= 1'b1;
         else if (lsr_rd_stb)           brk <= 1'b0;
         else if (leaves_empty)         brk <= 1'b0;

         if (ovf)             overrun <= 1'b1;
         else if (lsr_rd_stb) overrun <= 1'b0;

         if (clr || rd_stb)                  timeout_ind <= 1'b0;
         else if (expire && fill != '0)      timeout_ind <= 1'b1;
      end
   end

   assign rd_data    = fifo_en ? ((fill == '0) ? 8'h00 : q_rdata) : hold;
   assign data_avail = fifo_en ? (data_ready && int'(fill) >= trig_level(trig_sel))
                               : data_ready;
endmodule

// File: rtl/uart_rx_queue_chk.sv
module uart_rx_queue_chk #(
   parameter int DEPTH = 16
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       fifo_en,
   input logic                       fifo_clr,
   input logic                       rx_valid,
   input logic                       rx_break,
   input logic                       rd_stb,
   input logic [$clog2(DEPTH+1)-1:0] fill,
   input logic                       data_ready,
   input logic                       overrun,
   input logic                       brk,
   input logic                       timeout_ind
);
   AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      int'(fill) <= DEPTH); // R1

   AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_en && $stable(fifo_en) && !fifo_clr && !rd_stb && int'(fill) == DEPTH
       && (rx_valid || rx_break)) |=> (overrun && int'(fill) == DEPTH)); // R1

   AST_READ_DROPS_TMO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb |=> !timeout_ind); // R6

   AST_BREAK_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_break && !fifo_clr && $stable(fifo_en)) |=> (brk && data_ready)); // R8

   AST_SINGLE_OVR: assert property (@(posedge clk) disable iff (!rst_n)
      (!fifo_en && $stable(fifo_en) && !fifo_clr && data_ready && rx_valid) |=> overrun); // R9

   AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_clr |=> (fill == '0 && !data_ready && !brk && !timeout_ind)); // R10

   AST_NO_TMO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_en |=> !timeout_ind); // R13
endmodule

bind uart_rx_queue uart_rx_queue_chk #(.DEPTH(DEPTH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .fifo_en     (fifo_en),
   .fifo_clr    (fifo_clr),
   .rx_valid    (rx_valid),
   .rx_break    (rx_break),
   .rd_stb      (rd_stb),
   .fill        (fill),
   .data_ready  (data_ready),
   .overrun     (overrun),
   .brk         (brk),
   .timeout_ind (timeout_ind)
);

// File: tb/sim_uart_rx_queue.sv
module sim_uart_rx_queue;
   localparam int DEPTH = 16;

   logic       clk = 0, rst_n = 0;
   logic       fifo_en = 0, fifo_clr = 0, baud_tick = 0;
   logic       rx_valid = 0, rx_break = 0, rd_stb = 0, lsr_rd_stb = 0;
   logic [1:0] trig_sel = 0;
   logic [3:0] line_ctl = 0;
   logic [7:0] rx_data = 0;
   logic [7:0] rd_data;
   logic [4:0] fill;
   logic       data_ready, overrun, brk, data_avail, timeout_ind;

   int checks = 0, errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   uart_rx_queue #(.DEPTH(DEPTH), .TMO_FRAMES(4)) u0 (
      .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .fifo_clr(fifo_clr),
      .trig_sel(trig_sel), .line_ctl(line_ctl), .baud_tick(baud_tick),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_break(rx_break),
      .rd_stb(rd_stb), .lsr_rd_stb(lsr_rd_stb), .rd_data(rd_data),
      .fill(fill), .data_ready(data_ready), .overrun(overrun), .brk(brk),
      .data_avail(data_avail), .timeout_ind(timeout_ind)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic push(input logic [7:0] b);
      rx_valid = 1; rx_data = b; cyc(); rx_valid = 0;
   endtask

   task automatic push_break();
      rx_break = 1; cyc(); rx_break = 0;
   endtask

   task automatic pop(output logic [7:0] b);
      b = rd_data; rd_stb = 1; cyc(); rd_stb = 0;
   endtask

   task automatic lsr_read();
      lsr_rd_stb = 1; cyc(); lsr_rd_stb = 0;
   endtask

   task automatic clear();
      fifo_clr = 1; cyc(); fifo_clr = 0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         baud_tick = 1; cyc(); baud_tick = 0;
      end
   endtask

   function automatic int tmo_len(input logic [3:0] lc);
      return 4 * (7 + int'(lc[1:0]) + int'(lc[2]) + int'(lc[3]));
   endfunction

   function automatic int trig_of(input int c);
      return (c == 0) ? 1 : (c == 1) ? 4 : (c == 2) ? 8 : 14;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] b;
      int L;
      repeat (3) cyc();
      rst_n = 1;
      cyc();
      chk("reset fill", fill, 0);
      chk("reset data_ready", data_ready, 0);
      chk("reset overrun/brk", {overrun, brk}, 0);
      chk("reset avail/timeout", {data_avail, timeout_ind}, 0);

      fifo_en = 1; cyc();

      // R1 R2 R3 R7 R11: trigger sweep with fill, overflow and drain
      for (int c = 0; c < 4; c++) begin
         trig_sel = 2'(c);
         clear();
         for (int k = 1; k <= DEPTH; k++) begin
            push(8'(c * 40 + k));
            chk("R2 fill", fill, k);
            chk("R2 data_avail", data_avail, int'(k >= trig_of(c)));
         end
         push(8'hEE);
         chk("R1 overrun on full", overrun, 1);
         chk("R1 fill kept", fill, DEPTH);
         for (int k = 1; k <= DEPTH; k++) begin
            pop(b);
            chk("R3 order", b, (c * 40 + k) & 255);
            chk("R7 data_ready", data_ready, int'(k < DEPTH));
         end
         chk("R11 overrun survives data reads", overrun, 1);
         pop(b);
         chk("R3 empty read", b, 0);
         lsr_read();
         chk("R11 overrun cleared by status read", overrun, 0);
      end

      // R4 R5 R6: timeout length for every line setting
      for (int lc = 0; lc < 16; lc++) begin
         line_ctl = 4'(lc);
         clear();
         L = tmo_len(4'(lc));
         push(8'h5A);
         ticks(L - 1);
         chk("R4 no timeout one tick early", timeout_ind, 0);
         ticks(1);
         chk("R4 timeout on time", timeout_ind, 1);
         pop(b);
         chk("R6 read clears timeout", timeout_ind, 0);
      end

      // R5: read leaving data restarts; expiry on empty stays silent
      line_ctl = 4'h0; clear(); L = tmo_len(4'h0);
      push(8'h01); push(8'h02);
      ticks(L);
      chk("R5 timeout with two bytes", timeout_ind, 1);
      pop(b);
      chk("R6 cleared", timeout_ind, 0);
      ticks(L - 1);
      chk("R5 restarted by read", timeout_ind, 0);
      ticks(1);
      chk("R5 expiry after read restart", timeout_ind, 1);
      pop(b);
      ticks(L + 2);
      chk("R5 empty store gives no timeout", timeout_ind, 0);

      // R12: rescale on line setting change
      clear();
      push(8'h33);
      ticks(10);
      line_ctl = 4'hF; cyc();
      ticks(tmo_len(4'hF) - 1);
      chk("R12 rescaled no early timeout", timeout_ind, 0);
      ticks(1);
      chk("R12 rescaled timeout", timeout_ind, 1);
      line_ctl = 4'h0;
      clear();

      // R8 R7 R11: break handling
      push_break();
      chk("R8 break fill", fill, 1);
      chk("R8 break flags", {brk, data_ready}, 3);
      pop(b);
      chk("R8 break byte", b, 0);
      chk("R7 flags clear on empty", {brk, data_ready}, 0);
      push(8'hA5); push_break();
      pop(b);
      chk("R3 byte before break", b, 8'hA5);
      chk("R7 brk held while not empty", brk, 1);
      lsr_read();
      chk("R11 brk cleared by status read", brk, 0);
      pop(b);

      // R10: clear and enable change
      push(8'h10); push(8'h11); push(8'h12);
      ticks(tmo_len(4'h0) - 3);
      clear();
      chk("R10 clear fill", fill, 0);
      chk("R10 clear data_ready", data_ready, 0);
      ticks(tmo_len(4'h0));
      chk("R10 timeout cancelled", timeout_ind, 0);
      push(8'h20); push_break();
      fifo_en = 0; cyc();
      chk("R10 enable change empties", fill, 0);
      chk("R10 enable change flags", {data_ready, brk}, 0);

      // R9 R13: single-byte mode
      push(8'h11);
      chk("R9 data_ready", data_ready, 1);
      chk("R9 avail follows ready", data_avail, 1);
      chk("R9 held byte", rd_data, 8'h11);
      push(8'h22);
      chk("R9 overrun", overrun, 1);
      chk("R9 byte replaced", rd_data, 8'h22);
      ticks(60);
      chk("R13 no timeout", timeout_ind, 0);
      pop(b);
      chk("R9 read value", b, 8'h22);
      chk("R7 single read clears ready", data_ready, 0);
      chk("R11 overrun stays", overrun, 1);
      lsr_read();
      chk("R11 overrun cleared", overrun, 0);
      push_break();
      chk("R8 single break flags", {brk, data_ready}, 3);
      chk("R8 single break byte", rd_data, 0);
      pop(b);
      chk("R7 single read clears brk", brk, 0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule